// File: doc/BRIEF.md
# Interrupt vector priority decoder

This block sits beside a 16-bit CPU core. It collects every exception and interrupt request and tells the core when one of them needs service. When the core later asks for a vector, the block returns the 16-bit address of the vector table entry. The winner is decided at the moment the core asks, not when the request was first seen. A request that is higher in rank and arrives in between therefore takes the slot of the one that started the sequence.

Several lines feed the block. Five come from fixed exceptions that cannot be masked: system reset, clock-monitor failure, watchdog timeout, illegal opcode and software interrupt. A sixth, the high-rank external interrupt, is gated by the CPU's X mask bit. Below these sit a periodic-timer source and `NUM_SRC` general sources, all gated by the CPU's I mask bit. A one-byte promotion register can move a single general source to the top of the maskable group. The periodic timer then drops into the slot that source vacated.

If the core asks for a vector after the request that started the sequence has gone away, the block returns the last winner it recorded in the current sequence. If nothing was recorded, it returns the software-interrupt vector. A sequence-done strobe erases that record.

Top module: `irq_vector_arbiter`

## Requirements
- R1: With several non-maskable requests active, the vector returned follows this order: system reset 0xFFFE, clock monitor 0xFFFC, watchdog 0xFFFA, illegal opcode 0xFFF8, software interrupt 0xFFF6. The X-gated external interrupt comes next at 0xFFF4. The system reset vector 0xFFFE is also the value of `vec_addr` after reset.
- R2: Every maskable source ranks below the external interrupt. With the promotion register at its reset value, the periodic timer (0xFFF0) ranks first among them. It is followed by general source k at 0xFFEE − 2k, with source 0 highest.
- R3: While `i_mask` is 1, the periodic timer and the general sources are ignored, and `xirq_req` is ignored while `x_mask` is 1. The five non-maskable lines are never gated.
- R4: `irq_pending` is 1 in the same cycle as any request that passes its mask, and 0 in the same cycle once none does, with no register on the path.
- R5: A `vec_req` high at a rising clock edge loads `vec_addr` with the winner present at that edge, so a later, higher-ranked request overrides an earlier one. `vec_addr` keeps its value on every edge without `vec_req`.
- R6: If no request passes its mask at a `vec_req` edge, `vec_addr` takes the last winner recorded at any earlier edge since the previous `seq_done` or reset.
- R7: If no request passes its mask at a `vec_req` edge and nothing has been recorded since the last `seq_done` or reset, `vec_addr` becomes 0xFFF6. A `seq_done` edge clears the record.
- R8: Writing the low byte of a general source's vector (0xEE − 2k) into the promotion register makes that source the highest maskable source. The periodic timer then takes the rank the source had, and the other sources keep their order.
- R9: The promotion register resets to 0xF0, which is the periodic timer's low byte and means no promotion. Writing 0xF0 restores the default order. A write of any byte that is neither 0xF0 nor a general source's low byte is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sysrst_req | input | 1 | System reset request (non-maskable) |
| clkmon_req | input | 1 | Clock-monitor failure request (non-maskable) |
| cop_req | input | 1 | Watchdog timeout request (non-maskable) |
| illop_req | input | 1 | Illegal-opcode trap request (non-maskable) |
| swi_req | input | 1 | Software interrupt request (non-maskable) |
| xirq_req | input | 1 | High-rank external interrupt, gated by `x_mask` |
| src_req | input | NUM_SRC | General maskable sources, bit k is source k |
| rti_req | input | 1 | Periodic-timer maskable source |
| i_mask | input | 1 | CPU I mask bit, 1 blocks maskable sources |
| x_mask | input | 1 | CPU X mask bit, 1 blocks `xirq_req` |
| vec_req | input | 1 | Vector request strobe from the CPU |
| seq_done | input | 1 | End-of-sequence strobe, clears the recorded winner |
| prom_wr | input | 1 | Write strobe for the promotion register |
| prom_wdata | input | 8 | Low byte of the vector to promote |
| irq_pending | output | 1 | Any unmasked request present |
| vec_addr | output | 16 | Vector address returned to the CPU |

## Verification
The bench builds the block with its default of eight general sources. With that value every promotion target is within reach, from source 0 down to source 7, along with the full range of legal and illegal promotion bytes. The promotion test moves source 3. This places the periodic timer in a middle slot, where both the sources above it and those below it can be compared with it. The cycle model runs alongside and compares both outputs on every clock. It also covers the mask gating, late overrides, and fallback both with and without a recorded winner.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam logic [15:0] VEC_SYSRST  = 16'hFFFE;
    localparam logic [15:0] VEC_CLKMON  = 16'hFFFC;
    localparam logic [15:0] VEC_COP     = 16'hFFFA;
    localparam logic [15:0] VEC_ILLOP   = 16'hFFF8;
    localparam logic [15:0] VEC_SWI     = 16'hFFF6;
    localparam logic [15:0] VEC_XIRQ    = 16'hFFF4;
    localparam logic [15:0] VEC_RTI     = 16'hFFF0;
    localparam logic [15:0] VEC_SRC_TOP = 16'hFFEE;

    // Vector of general source k; source 0 is highest
    function automatic logic [15:0] src_vec(input int k);
        return VEC_SRC_TOP - 16'(2 * k);
    endfunction

    function automatic logic [7:0] src_lo(input int k);
        return VEC_SRC_TOP[7:0] - 8'(2 * k);
    endfunction

    typedef struct packed {
        logic [7:0] prom;
    } prom_state_t;

    typedef struct packed {
        logic [15:0] vec;
        logic [15:0] hold;
        logic        hold_vld;
    } hold_state_t;

endpackage

// File: rtl/irq_promote_reg.sv
module irq_promote_reg
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             prom_active,
    output logic [IDX_W-1:0] prom_idx
);

    prom_state_t state_d, state_q;
    logic        wr_legal;

    always_comb begin
        wr_legal = (wr_data == VEC_RTI[7:0]);
        for (int k = 0; k < NUM_SRC; k++) begin
            if (wr_data == src_lo(k)) wr_legal = 1'b1;
        end
        state_d = state_q;
        if (wr_en && wr_legal) state_d.prom = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q.prom <= VEC_RTI[7:0];
        else        state_q      <= state_d;
    end

    always_comb begin
        prom_active = 1'b0;
        prom_idx    = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (state_q.prom == src_lo(k)) begin
                prom_active = 1'b1;
                prom_idx    = IDX_W'(k);
            end
        end
    end

    // R9: the stored byte is always a legal target
    assert_prom_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.prom == VEC_RTI[7:0]) ||
        (!state_q.prom[0] && state_q.prom <= src_lo(0) && state_q.prom >= src_lo(NUM_SRC-1)));

endmodule

// File: rtl/irq_maskable_arb.sv
module irq_maskable_arb
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_live,
    input  logic               rti_live,
    input  logic               prom_active,
    input  logic [IDX_W-1:0]   prom_idx,
    output logic               hit,
    output logic [15:0]        vec
);

    logic        top_req;
    logic [15:0] top_vec;
    logic        slot_req;
    logic [15:0] slot_vec;

    always_comb begin
        hit      = 1'b0;
        vec      = VEC_RTI;
        slot_req = 1'b0;
        slot_vec = VEC_RTI;
        // scan upward in rank so the highest slot overwrites last
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (prom_active && prom_idx == IDX_W'(k)) begin
                slot_req = rti_live;
                slot_vec = VEC_RTI;
            end else begin
                slot_req = src_live[k];
                slot_vec = src_vec(k);
            end
            if (slot_req) begin
                hit = 1'b1;
                vec = slot_vec;
            end
        end
        top_req = prom_active ? src_live[prom_idx] : rti_live;
        top_vec = prom_active ? src_vec(int'(prom_idx)) : VEC_RTI;
        if (top_req) begin
            hit = 1'b1;
            vec = top_vec;
        end
    end

    // R8: an active promoted source always wins the maskable group
    assert_promoted_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prom_active && src_live[prom_idx]) |-> (vec == src_vec(int'(prom_idx))));

endmodule

// File: rtl/irq_vector_hold.sv
module irq_vector_hold
    import irq_vec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vec_req,
    input  logic        seq_done,
    input  logic        hit,
    input  logic [15:0] win_vec,
    output logic [15:0] vec_addr
);

    hold_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (vec_req) begin
            if (hit)                   state_d.vec = win_vec;
            else if (state_q.hold_vld) state_d.vec = state_q.hold;
            else                       state_d.vec = VEC_SWI;
        end
        if (seq_done) begin
            state_d.hold_vld = 1'b0;
            state_d.hold     = '0;
        end else if (hit) begin
            state_d.hold_vld = 1'b1;
            state_d.hold     = win_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.vec      <= VEC_SYSRST;
            state_q.hold     <= '0;
            state_q.hold_vld <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign vec_addr = state_q.vec;

    assert_vec_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |=> $stable(vec_addr));

    assert_swi_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !hit && !state_q.hold_vld) |=> (vec_addr == VEC_SWI));

    assert_hold_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !state_q.hold_vld);

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sysrst_req,
    input  logic               clkmon_req,
    input  logic               cop_req,
    input  logic               illop_req,
    input  logic               swi_req,
    input  logic               xirq_req,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               rti_req,
    input  logic               i_mask,
    input  logic               x_mask,
    input  logic               vec_req,
    input  logic               seq_done,
    input  logic               prom_wr,
    input  logic [7:0]         prom_wdata,
    output logic               irq_pending,
    output logic [15:0]        vec_addr
);

    logic [NUM_SRC-1:0] src_live;
    logic               rti_live;
    logic               xirq_live;
    logic               prom_active;
    logic [IDX_W-1:0]   prom_idx;
    logic               mask_hit;
    logic [15:0]        mask_vec;
    logic               win_hit;
    logic [15:0]        win_vec;

    assign src_live  = i_mask ? '0 : src_req;
    assign rti_live  = rti_req & ~i_mask;
    assign xirq_live = xirq_req & ~x_mask;

    irq_promote_reg #(.NUM_SRC(NUM_SRC)) u_prom (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (prom_wr),
        .wr_data     (prom_wdata),
        .prom_active (prom_active),
        .prom_idx    (prom_idx)
    );

    irq_maskable_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_live    (src_live),
        .rti_live    (rti_live),
        .prom_active (prom_active),
        .prom_idx    (prom_idx),
        .hit         (mask_hit),
        .vec         (mask_vec)
    );

    always_comb begin
        win_hit = 1'b1;
        if      (sysrst_req) win_vec = VEC_SYSRST;
        else if (clkmon_req) win_vec = VEC_CLKMON;
        else if (cop_req)    win_vec = VEC_COP;
        else if (illop_req)  win_vec = VEC_ILLOP;
        else if (swi_req)    win_vec = VEC_SWI;
        else if (xirq_live)  win_vec = VEC_XIRQ;
        else begin
            win_hit = mask_hit;
            win_vec = mask_vec;
        end
    end

    assign irq_pending = win_hit;

    irq_vector_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .vec_req  (vec_req),
        .seq_done (seq_done),
        .hit      (win_hit),
        .win_vec  (win_vec),
        .vec_addr (vec_addr)
    );

    // R3: the watchdog exception passes regardless of both mask bits
    assert_cop_unmaskable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && cop_req && !sysrst_req && !clkmon_req) |=> (vec_addr == VEC_COP));

    // R2: maskable vectors never beat the external interrupt
    assert_xirq_over_maskable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && xirq_req && !x_mask && !sysrst_req && !clkmon_req && !cop_req
         && !illop_req && !swi_req) |=> (vec_addr == VEC_XIRQ));

endmodule

// File: tb/sim_irq_vector_arbiter.sv
module sim_irq_vector_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sysrst_req = 0, clkmon_req = 0, cop_req = 0, illop_req = 0, swi_req = 0;
    logic        xirq_req = 0, rti_req = 0, i_mask = 0, x_mask = 0;
    logic [7:0]  src_req = '0;
    logic        vec_req = 0, seq_done = 0, prom_wr = 0;
    logic [7:0]  prom_wdata = '0;
    logic        irq_pending;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_vector_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .sysrst_req(sysrst_req), .clkmon_req(clkmon_req),
        .cop_req(cop_req), .illop_req(illop_req), .swi_req(swi_req), .xirq_req(xirq_req),
        .src_req(src_req), .rti_req(rti_req), .i_mask(i_mask), .x_mask(x_mask),
        .vec_req(vec_req), .seq_done(seq_done), .prom_wr(prom_wr), .prom_wdata(prom_wdata),
        .irq_pending(irq_pending), .vec_addr(vec_addr)
    );

    // ---------------- reference model ----------------
    int          m_prom;       // 8 = no promotion
    logic [15:0] m_hold;
    bit          m_hold_vld;
    logic [15:0] exp_vec;

    function automatic logic [16:0] model_pick();
        int order[$];
        if (sysrst_req) return {1'b1, 16'hFFFE};
        if (clkmon_req) return {1'b1, 16'hFFFC};
        if (cop_req)    return {1'b1, 16'hFFFA};
        if (illop_req)  return {1'b1, 16'hFFF8};
        if (swi_req)    return {1'b1, 16'hFFF6};
        if (xirq_req && !x_mask) return {1'b1, 16'hFFF4};
        if (i_mask) return 17'd0;
        if (m_prom == 8) begin
            order.push_back(8);
            for (int j = 0; j < 8; j++) order.push_back(j);
        end else begin
            order.push_back(m_prom);
            for (int j = 0; j < 8; j++) order.push_back(j == m_prom ? 8 : j);
        end
        foreach (order[n]) begin
            int s;
            s = order[n];
            if (s == 8) begin
                if (rti_req) return {1'b1, 16'hFFF0};
            end else if (src_req[s]) begin
                return {1'b1, 16'hFFEE - 16'(2 * s)};
            end
        end
        return 17'd0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prom     <= 8;
            m_hold     <= '0;
            m_hold_vld <= 0;
            exp_vec    <= 16'hFFFE;
        end else begin
            logic [16:0] pk;
            pk = model_pick();
            if (vec_req) exp_vec <= pk[16] ? pk[15:0] : (m_hold_vld ? m_hold : 16'hFFF6);
            if (seq_done) m_hold_vld <= 0;
            else if (pk[16]) begin m_hold_vld <= 1; m_hold <= pk[15:0]; end
            if (prom_wr) begin
                if (prom_wdata == 8'hF0) m_prom <= 8;
                else if (prom_wdata >= 8'hE0 && prom_wdata <= 8'hEE && !prom_wdata[0])
                    m_prom <= (8'hEE - int'(prom_wdata)) / 2;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            logic [16:0] pk;
            pk = model_pick();
            chk(vec_addr == exp_vec, "R5 per-cycle vector", vec_addr, exp_vec);
            chk(irq_pending == pk[16], "R4 per-cycle pending", 16'(irq_pending), 16'(pk[16]));
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic ask(input string tag, input logic [15:0] exp);
        vec_req = 1;
        tick();
        vec_req = 0;
        chk(vec_addr == exp, tag, vec_addr, exp);
    endtask

    task automatic clear_all();
        sysrst_req = 0; clkmon_req = 0; cop_req = 0; illop_req = 0; swi_req = 0;
        xirq_req = 0; rti_req = 0; src_req = '0; i_mask = 0; x_mask = 0;
    endtask

    task automatic end_seq();
        seq_done = 1;
        tick();
        seq_done = 0;
    endtask

    task automatic promote(input logic [7:0] b);
        prom_wr = 1; prom_wdata = b;
        tick();
        prom_wr = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        chk(vec_addr == 16'hFFFE, "R1 reset vector", vec_addr, 16'hFFFE);
        chk(irq_pending == 0, "R4 idle after reset", 16'(irq_pending), 16'h0);
        rst_n = 1;
        tick();

        // R7: nothing ever pending
        ask("R7 swi default", 16'hFFF6);

        // R1: non-maskable order
        sysrst_req = 1; clkmon_req = 1; cop_req = 1; illop_req = 1; swi_req = 1; xirq_req = 1;
        rti_req = 1; src_req = 8'hFF;
        ask("R1 system reset first", 16'hFFFE);
        sysrst_req = 0; ask("R1 clock monitor", 16'hFFFC);
        clkmon_req = 0; ask("R1 watchdog", 16'hFFFA);
        cop_req = 0;    ask("R1 illegal opcode", 16'hFFF8);
        illop_req = 0;  ask("R1 software interrupt", 16'hFFF6);
        swi_req = 0;    ask("R1 external interrupt", 16'hFFF4);
        xirq_req = 0;   ask("R2 periodic timer first maskable", 16'hFFF0);
        rti_req = 0;    ask("R2 source 0", 16'hFFEE);
        src_req = 8'h80; ask("R2 source 7", 16'hFFE0);

        // R3: masks
        clear_all(); src_req = 8'h08; i_mask = 1; #1;
        chk(irq_pending == 0, "R3 I mask blocks source", 16'(irq_pending), 16'h0);
        src_req = 0; i_mask = 0; xirq_req = 1; x_mask = 1; #1;
        chk(irq_pending == 0, "R3 X mask blocks external", 16'(irq_pending), 16'h0);
        cop_req = 1; i_mask = 1;
        ask("R3 watchdog ignores masks", 16'hFFFA);
        clear_all(); end_seq();

        // R4: same-cycle pending
        src_req = 8'h04; #1;
        chk(irq_pending == 1, "R4 pending same cycle", 16'(irq_pending), 16'h1);
        src_req = 0; #1;
        chk(irq_pending == 0, "R4 pending drops same cycle", 16'(irq_pending), 16'h0);

        // R5: late higher request overrides
        src_req = 8'h20; tick();
        src_req = 8'h22;
        ask("R5 later request overrides", 16'hFFEC);
        clear_all(); end_seq();

        // R6 fallback then R7 after seq_done
        src_req = 8'h10; tick();
        src_req = 0;
        ask("R6 last valid fallback", 16'hFFE6);
        end_seq();
        ask("R7 swi after seq_done", 16'hFFF6);

        // R8 promotion of source 3
        promote(8'hE8);
        rti_req = 1; src_req = 8'h09;
        ask("R8 promoted source wins", 16'hFFE8);
        src_req = 8'h01;
        ask("R8 source 0 above displaced timer", 16'hFFEE);
        src_req = 8'h10;
        ask("R8 timer in vacated slot above source 4", 16'hFFF0);
        clear_all(); end_seq();

        // R9 illegal writes ignored, 0xF0 restores default
        promote(8'hE7);
        promote(8'hF2);
        src_req = 8'h09;
        ask("R9 illegal write ignored", 16'hFFE8);
        promote(8'hF0);
        rti_req = 1; src_req = 8'h08;
        ask("R9 default order restored", 16'hFFF0);
        clear_all(); end_seq();

        tick(); tick();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule